// File: doc/BRIEF.md
# Per-Line Edge Event Detector

This block watches a bus of single-bit monitor lines (256 by default). On every clock it compares the current sample of each line with the sample taken one cycle earlier. Each line has its own selection of which transitions count: a rising edge, a falling edge, or either edge. A per-line mask then decides whether a detected transition is reported. The result is a one-cycle pulse on that line's bit of an event vector, and an any-event flag is raised in the same cycle.

Software-style configuration goes through a flat 32-bit register port. A write takes one cycle and reads are combinational. Selector fields are packed sixteen lines per word and mask bits thirty-two lines per word. A single global enable bit starts and stops detection. When detection is re-armed, it first takes a fresh reference sample, so lines that changed while the block was idle produce no events.

Top module: `edge_monitor`

## Requirements
- R1: Line n's selector is the 2-bit field at bits [2*(n%16)+1 : 2*(n%16)] of selector word n/16. Value 0 reports a 0-to-1 change, value 1 reports a 1-to-0 change, and value 2 reports any change.
- R2: A write to a selector word updates every field whose written value is 0, 1 or 2. A field written as 3 keeps its previous value.
- R3: Line n's mask bit is bit n%32 of mask word n/32. A set bit lets that line's events through. A clear bit suppresses them.
- R4: The global enable is bit 0 of the register at word address 0. While it is clear, every event output stays 0 whatever the lines do.
- R5: On the first clock edge after the enable becomes set, the reference sample is reloaded from the lines and no event is produced at that edge.
- R6: A change sampled at clock edge k appears on the event vector right after edge k. If the line is then stable, the event is gone after edge k+1.
- R7: any_event is 1 exactly when at least one bit of line_events is 1, in the same cycle.
- R8: After reset, all selector words, mask words and the enable read as 0. A read returns the stored word, including fields of masked lines.
- R9: The word address map places the control register at 0, selector word i at 16+i and mask word j at 32+j. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe for one cycle |
| reg_addr | input | ADDR_W (6) | Word address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lines_in | input | NUM_LINES (256) | Monitored lines |
| line_events | output | NUM_LINES (256) | One-cycle event pulse per line |
| any_event | output | 1 | OR of all line events |

## Verification
Internal faults surface at the ports within one or two edges. A wrong reference sample shows as an event pulse one cycle after the fault, on a line whose input never moved. A selector field or mask bit stored in the wrong place shows immediately on readback. It also shows as an event on the wrong line at the first matching transition. A missing re-arm is exposed on the first edge after the enable is set, when lines that changed while idle would fire.

// File: rtl/edge_monitor_pkg.sv
package edge_monitor_pkg;

  localparam int REG_W           = 32;
  localparam int SEL_W           = 2;
  localparam int SELS_PER_WORD   = REG_W / SEL_W;
  localparam int MASKS_PER_WORD  = REG_W;
  localparam int CTRL_ADDR       = 0;
  localparam int SEL_BASE        = 16;
  localparam int MASK_BASE       = 32;

  typedef enum logic [SEL_W-1:0] {
    KIND_RISE = 2'd0,
    KIND_FALL = 2'd1,
    KIND_ANY  = 2'd2,
    KIND_RSVD = 2'd3
  } edge_kind_e;

  // True when the selected kind of transition occurred between two samples.
  function automatic logic kind_hit(logic [SEL_W-1:0] kind, logic was, logic now);
    case (edge_kind_e'(kind))
      KIND_RISE: kind_hit = now & ~was;
      KIND_FALL: kind_hit = was & ~now;
      KIND_ANY:  kind_hit = was ^ now;
      default:   kind_hit = 1'b0;
    endcase
  endfunction

  // Per-field write merge: a reserved code keeps the stored field.
  function automatic logic [REG_W-1:0] sel_merge(logic [REG_W-1:0] held,
                                                 logic [REG_W-1:0] incoming);
    logic [REG_W-1:0] res;
    res = held;
    for (int f = 0; f < SELS_PER_WORD; f++) begin
      if (incoming[f*SEL_W +: SEL_W] != KIND_RSVD)
        res[f*SEL_W +: SEL_W] = incoming[f*SEL_W +: SEL_W];
    end
    return res;
  endfunction

  // True when any field of the word holds the reserved code.
  function automatic logic has_rsvd(logic [REG_W-1:0] w);
    logic bad;
    bad = 1'b0;
    for (int f = 0; f < SELS_PER_WORD; f++)
      if (w[f*SEL_W +: SEL_W] == KIND_RSVD) bad = 1'b1;
    return bad;
  endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
  import edge_monitor_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int ADDR_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic                   enable,
  output logic [SEL_W*NUM_LINES-1:0] sel_flat,
  output logic [NUM_LINES-1:0]   mask_flat
);

  localparam int SEL_WORDS  = (SEL_W * NUM_LINES) / REG_W;
  localparam int MASK_WORDS = NUM_LINES / MASKS_PER_WORD;

  logic [REG_W-1:0] sel_q  [SEL_WORDS];
  logic [REG_W-1:0] mask_q [MASK_WORDS];
  logic             en_q;

  logic hit_ctrl;
  assign hit_ctrl = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      for (int i = 0; i < SEL_WORDS; i++)  sel_q[i]  <= '0;
      for (int j = 0; j < MASK_WORDS; j++) mask_q[j] <= '0;
    end else if (reg_we) begin
      if (hit_ctrl) en_q <= reg_wdata[0];
      for (int i = 0; i < SEL_WORDS; i++)
        if (reg_addr == ADDR_W'(SEL_BASE + i))
          sel_q[i] <= sel_merge(sel_q[i], reg_wdata);
      for (int j = 0; j < MASK_WORDS; j++)
        if (reg_addr == ADDR_W'(MASK_BASE + j))
          mask_q[j] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(CTRL_ADDR)) reg_rdata = {{(REG_W-1){1'b0}}, en_q};
    for (int i = 0; i < SEL_WORDS; i++)
      if (reg_addr == ADDR_W'(SEL_BASE + i)) reg_rdata = sel_q[i];
    for (int j = 0; j < MASK_WORDS; j++)
      if (reg_addr == ADDR_W'(MASK_BASE + j)) reg_rdata = mask_q[j];
  end

  assign enable = en_q;

  generate
    for (genvar gi = 0; gi < SEL_WORDS; gi++) begin : g_sel
      assign sel_flat[gi*REG_W +: REG_W] = sel_q[gi];

      // R2
      no_rsvd_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !has_rsvd(sel_q[gi]));

      // R2
      rsvd_keeps_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(SEL_BASE + gi) && reg_wdata[1:0] == 2'b11)
        |=> $stable(sel_q[gi][1:0]));
    end
    for (genvar gj = 0; gj < MASK_WORDS; gj++) begin : g_mask
      assign mask_flat[gj*REG_W +: REG_W] = mask_q[gj];
    end
  endgenerate

endmodule

// File: rtl/edge_sampler.sv
module edge_sampler #(
  parameter int NUM_LINES = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [NUM_LINES-1:0] lines_in,
  output logic [NUM_LINES-1:0] ref_q,
  output logic                 armed_q,
  output logic                 detect_ok
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= enable;
      if (enable) ref_q <= lines_in;
    end
  end

  assign detect_ok = enable && armed_q;

  // R5
  rearm_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> (ref_q == $past(lines_in)));

endmodule

// File: rtl/edge_line_cell.sv
module edge_line_cell
  import edge_monitor_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] kind,
  input  logic             pass,
  input  logic             detect_ok,
  input  logic             was,
  input  logic             now,
  output logic             ev_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= 1'b0;
    else        ev_q <= detect_ok & pass & kind_hit(kind, was, now);
  end

  // R3
  mask_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_q |-> $past(pass));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q && $stable(now)) |=> !ev_q);

endmodule

// File: rtl/edge_monitor.sv
module edge_monitor
  import edge_monitor_pkg::*;
#(
  parameter int NUM_LINES = 256,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] lines_in,
  output logic [NUM_LINES-1:0] line_events,
  output logic                 any_event
);

  logic                       enable;
  logic [SEL_W*NUM_LINES-1:0] sel_flat;
  logic [NUM_LINES-1:0]       mask_flat;
  logic [NUM_LINES-1:0]       ref_q;
  logic                       armed_q;
  logic                       detect_ok;

  edge_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .enable    (enable),
    .sel_flat  (sel_flat),
    .mask_flat (mask_flat)
  );

  edge_sampler #(.NUM_LINES(NUM_LINES)) u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .lines_in  (lines_in),
    .ref_q     (ref_q),
    .armed_q   (armed_q),
    .detect_ok (detect_ok)
  );

  generate
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      edge_line_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (sel_flat[n*SEL_W +: SEL_W]),
        .pass      (mask_flat[n]),
        .detect_ok (detect_ok),
        .was       (ref_q[n]),
        .now       (lines_in[n]),
        .ev_q      (line_events[n])
      );
    end
  endgenerate

  assign any_event = |line_events;

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (line_events == '0));

  // R5
  arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> !any_event);

endmodule

// File: tb/edge_monitor_tb.sv
module edge_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 256;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  lines_in = '0;
  logic [N-1:0]  line_events;
  logic          any_event;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [2*N-1:0] sh_sel  = '0;
  logic [N-1:0]   sh_mask = '0;
  bit             sh_en = 0;
  bit             fresh = 0;
  logic [N-1:0]   prev_b = '0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  edge_monitor #(.NUM_LINES(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lines_in(lines_in),
    .line_events(line_events), .any_event(any_event)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] model(logic [N-1:0] p, logic [N-1:0] c);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) begin
      logic [1:0] k;
      logic h;
      k = sh_sel[(n/16)*32 + 2*(n%16) +: 2];
      if (k == 2'd0)      h = c[n] && !p[n];
      else if (k == 2'd1) h = p[n] && !c[n];
      else if (k == 2'd2) h = c[n] != p[n];
      else                h = 1'b0;
      r[n] = h && sh_mask[(n/32)*32 + (n%32)];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] rand_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    fresh = 0;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    if (a == 0) begin
      if (d[0] && !sh_en) fresh = 1;
      sh_en = d[0];
    end else if (a >= 16 && a < 32) begin
      for (int f = 0; f < 16; f++)
        if (d[2*f +: 2] != 2'b11) sh_sel[(a-16)*32 + 2*f +: 2] = d[2*f +: 2];
    end else if (a >= 32 && a < 40) begin
      sh_mask[(a-32)*32 +: 32] = d;
    end
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string req);
    fresh = 0;
    @(negedge clk);
    reg_addr = AW'(a);
    #1 check32(req, $sformatf("read addr %0d", a), reg_rdata, exp);
  endtask

  task automatic step(logic [N-1:0] v, string tag);
    logic [N-1:0] e;
    @(negedge clk);
    lines_in = v;
    if (!sh_en) e = '0;
    else if (fresh) begin e = '0; fresh = 0; end
    else e = model(prev_b, v);
    if (sh_en) prev_b = v;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares each expected item one step after its edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (line_events !== e) begin
          mismatched++;
          $display("FAIL %s events: actual %h expected %h", t, line_events, e);
        end
        compared++;
        if (any_event !== (|e)) begin
          mismatched++;
          $display("FAIL R7 %s any_event: actual %b expected %b", t, any_event, |e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check32("R8", "events after reset", {31'b0, |line_events}, 32'd0);
    check32("R7", "any_event after reset", {31'b0, any_event}, 32'd0);
    rd(0, 0, "R8"); rd(16, 0, "R8"); rd(31, 0, "R8"); rd(32, 0, "R8"); rd(39, 0, "R8");

    // R9 map, R2 reserved-code merge
    wr(16, 32'h0000_0006);
    rd(16, 32'h0000_0006, "R9");
    wr(16, 32'hFFFF_FFFC);
    rd(16, 32'h0000_0004, "R2");
    wr(16, 32'h0000_0003);
    rd(16, 32'h0000_0000, "R2");
    rd(40, 0, "R9"); rd(1, 0, "R9"); rd(15, 0, "R9");

    // Random config, readback including masked lines (R8, R1, R3)
    for (int w = 0; w < 16; w++) begin
      logic [31:0] d;
      for (int f = 0; f < 16; f++) d[2*f +: 2] = 2'($urandom % 3);
      wr(16 + w, d);
    end
    for (int m = 0; m < 8; m++) wr(32 + m, $urandom);
    wr(32, 32'h0000_FFFF);
    for (int w = 0; w < 16; w++) rd(16 + w, sh_sel[w*32 +: 32], "R8");
    for (int m = 0; m < 8; m++) rd(32 + m, sh_mask[m*32 +: 32], "R8");
    rd(0, 0, "R4");

    // R4 disabled: no events
    for (int i = 0; i < 4; i++) step(rand_vec(), "R4 disabled");

    // R5 enable: first edge reloads
    wr(0, 1);
    step(~lines_in, "R5 first enabled edge");
    rd(0, 1, "R4");

    // R1 R3 R6 random traffic with stable steps between
    for (int i = 0; i < 40; i++) begin
      step(rand_vec(), "R1 random");
      if (i % 4 == 0) step(lines_in, "R6 stable");
    end

    // R1 directed: line0 rise, line1 fall, line2 toggle, all unmasked
    wr(16, 32'h0000_0024);
    for (int m = 0; m < 8; m++) wr(32 + m, 32'hFFFF_FFFF);
    step('0, "R1 directed base");
    step(N'(3'b111), "R1 directed up");
    step(N'(3'b111), "R6 directed hold");
    step('0, "R1 directed down");
    step(N'(3'b101), "R1 directed mix");

    // R3 mask suppress while enabled
    for (int m = 0; m < 8; m++) wr(32 + m, 32'h0);
    for (int i = 0; i < 4; i++) step(rand_vec(), "R3 masked");
    for (int m = 0; m < 8; m++) wr(32 + m, 32'hA5A5_5A5A);
    for (int i = 0; i < 6; i++) step(rand_vec(), "R3 partial mask");

    // R4 disable, lines move, R5 re-enable
    wr(0, 0);
    for (int i = 0; i < 4; i++) step(rand_vec(), "R4 disabled again");
    v = rand_vec();
    wr(0, 1);
    step(~v, "R5 re-arm");
    for (int i = 0; i < 8; i++) step(rand_vec(), "R6 after re-arm");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule